// File: doc/BRIEF.md
# Transmit End-of-Message Controller

This block decides what a synchronous serial transmitter sends when its data path runs dry. It holds an end-of-message latch. While software keeps the latch clear, an underrun from the data path is treated as the end of a frame. The block then either appends the running CRC-16 or, in SDLC mode with the abort option, asks the bit-level transmitter for an abort followed by a closing flag. Starting either action sets the latch again, so a second underrun does nothing until software clears the latch once more.

Two command codes arrive on a small strobe-and-code interface. Code `2'b10` presets the CRC generator. Code `2'b11` clears the latch, but only while the transmitter is enabled. The CRC register accumulates one bit for every data bit the transmitter sends. A block reset never touches it; only the preset command does. A latch-clear command that arrives while the transmitter is disabled does not clear the latch. Instead it raises an external/status interrupt request, subject to a one-deep pending flag.

Top module: `tx_eom_ctrl`

## Requirements
- R1: After reset `eom_latch` is 1, `xs_pending` is 0, and `xs_irq`, `abort_req`, `flag_req` and `crc_valid` are all 0.
- R2: A command with `cmd_code` = 2'b10 presets the CRC register to all ones. Asserting `rst_n` leaves the CRC register unchanged.
- R3: The CRC register updates on each cycle with `data_valid` high, using the polynomial x^16+x^12+x^5+1 (feedback = register MSB xor `data_bit`). An append drives the 16-bit value MSB first on `crc_bit`, one bit per cycle, with `crc_valid` high for exactly 16 cycles. The append starts in the cycle after the underrun.
- R4: A command with `cmd_code` = 2'b11 clears `eom_latch` on the next edge when `tx_en` is 1. When `tx_en` is 0 the latch is left as it was.
- R5: The block appends the CRC, and sets `eom_latch` on the same edge, when all of the following hold: `underrun` is high, `tx_en` is 1, the latch is clear, the block is idle, and the abort choice (`sdlc_mode` and `abort_on_urun` both 1) is not selected.
- R6: Under the same underrun conditions with `sdlc_mode` and `abort_on_urun` both 1, `abort_req` is high for one cycle and is followed by `flag_req` for one cycle. The latch is set and no CRC is sent.
- R7: An underrun while `eom_latch` is 1 or `tx_en` is 0 produces no abort, flag or CRC.
- R8: A 2'b11 command with `tx_en` 0 pulses `xs_irq` for one cycle and sets `xs_pending` when `xs_pending` was 0. It does the same when `ext_clr` accompanies the command.
- R9: A 2'b11 command with `tx_en` 0, while `xs_pending` is 1 and `ext_clr` is 0, raises no `xs_irq`. `ext_clr` without such a command clears `xs_pending`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset (does not touch CRC) |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 2 | Command code: 2'b10 preset CRC, 2'b11 clear latch |
| ext_clr | input | 1 | Reset-external/status command |
| tx_en | input | 1 | Transmitter enable |
| data_valid | input | 1 | A data bit is being sent this cycle |
| data_bit | input | 1 | Data bit value |
| underrun | input | 1 | Data path underrun indication |
| sdlc_mode | input | 1 | SDLC framing selected |
| abort_on_urun | input | 1 | Abort-on-underrun option |
| eom_latch | output | 1 | End-of-message latch state |
| crc_valid | output | 1 | CRC bit is being appended |
| crc_bit | output | 1 | Current CRC bit, MSB first |
| abort_req | output | 1 | Send abort sequence |
| flag_req | output | 1 | Send closing flag |
| xs_irq | output | 1 | External/status interrupt request pulse |
| xs_pending | output | 1 | External/status interrupt pending |

## Verification
The assertions assume that `underrun` does not arrive in the same cycle as a latch-clear command. They also assume that `data_valid` stays low while an append or abort is in progress. The stimulus keeps to both: every command and every underrun has a cycle of its own, and data bits are fed only while the block is idle. Inputs change only on the falling clock edge, so each command is seen on exactly one rising edge.

// File: rtl/tx_eom_ctrl.sv
module tx_eom_ctrl #(
  parameter int CRC_W = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021,
  parameter logic [CRC_W-1:0] CRC_INIT = '1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic [1:0] cmd_code,
  input  logic ext_clr,
  input  logic tx_en,
  input  logic data_valid,
  input  logic data_bit,
  input  logic underrun,
  input  logic sdlc_mode,
  input  logic abort_on_urun,
  output logic eom_latch,
  output logic crc_valid,
  output logic crc_bit,
  output logic abort_req,
  output logic flag_req,
  output logic xs_irq,
  output logic xs_pending
);
  localparam int CW = $clog2(CRC_W);
  localparam logic [CW-1:0] LAST = CW'(CRC_W - 1);

  typedef enum logic [1:0] {IDLE, SEND, ABORT, FLAG} st_t;

  st_t st_q;
  logic [CRC_W-1:0] crc_q, sh_q;
  logic [CW-1:0] cnt_q;
  logic latch_q, irq_q, pend_q;

  wire cmd_crc   = cmd_valid && (cmd_code == 2'b10);
  wire cmd_eom   = cmd_valid && (cmd_code == 2'b11);
  wire go        = underrun && tx_en && !latch_q && (st_q == IDLE);
  wire use_abort = sdlc_mode && abort_on_urun;
  wire xs_trig   = cmd_eom && !tx_en && (!pend_q || ext_clr);
  wire fb        = crc_q[CRC_W-1] ^ data_bit;
  wire [CRC_W-1:0] crc_nx = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);

  always_ff @(posedge clk) begin
    if (cmd_crc) crc_q <= CRC_INIT;
    else if (data_valid) crc_q <= crc_nx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) latch_q <= 1'b1;
    else if (go) latch_q <= 1'b1;
    else if (cmd_eom && tx_en) latch_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      case (st_q)
        IDLE: if (go) begin
          st_q  <= use_abort ? ABORT : SEND;
          sh_q  <= crc_q;
          cnt_q <= '0;
        end
        SEND: begin
          sh_q  <= {sh_q[CRC_W-2:0], 1'b0};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) st_q <= IDLE;
        end
        ABORT: st_q <= FLAG;
        default: st_q <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      irq_q <= xs_trig;
      if (xs_trig) pend_q <= 1'b1;
      else if (ext_clr) pend_q <= 1'b0;
    end
  end

  assign eom_latch  = latch_q;
  assign crc_valid  = (st_q == SEND);
  assign crc_bit    = (st_q == SEND) && sh_q[CRC_W-1];
  assign abort_req  = (st_q == ABORT);
  assign flag_req   = (st_q == FLAG);
  assign xs_irq     = irq_q;
  assign xs_pending = pend_q;
endmodule

module tx_eom_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic [1:0] cmd_code,
  input logic tx_en,
  input logic underrun,
  input logic sdlc_mode,
  input logic abort_on_urun,
  input logic eom_latch,
  input logic crc_valid,
  input logic abort_req,
  input logic flag_req,
  input logic xs_irq,
  input logic xs_pending
);
  assert_hold_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (eom_latch && !tx_en) |=> eom_latch);
  assert_abort_then_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> (flag_req && !abort_req));
  assert_abort_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abort_req) |-> $past(underrun && sdlc_mode && abort_on_urun));
  assert_one_action_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({crc_valid, abort_req, flag_req}));
  assert_crc_sets_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_valid) |-> (eom_latch && $past(underrun && tx_en && !eom_latch)));
  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xs_irq |-> ($past(cmd_valid && cmd_code == 2'b11 && !tx_en) && xs_pending));
endmodule

bind tx_eom_ctrl tx_eom_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .tx_en(tx_en), .underrun(underrun), .sdlc_mode(sdlc_mode),
  .abort_on_urun(abort_on_urun), .eom_latch(eom_latch), .crc_valid(crc_valid),
  .abort_req(abort_req), .flag_req(flag_req), .xs_irq(xs_irq),
  .xs_pending(xs_pending)
);

// File: tb/tb_tx_eom_ctrl.sv
module tb_tx_eom_ctrl;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, ext_clr = 1'b0, tx_en = 1'b0;
  logic [1:0] cmd_code = 2'b00;
  logic data_valid = 1'b0, data_bit = 1'b0, underrun = 1'b0;
  logic sdlc_mode = 1'b0, abort_on_urun = 1'b0;
  logic eom_latch, crc_valid, crc_bit, abort_req, flag_req, xs_irq, xs_pending;

  int nvec = 0, nbad = 0;
  logic [15:0] m_crc;

  always #(CLK_P/2) clk = ~clk;

  tx_eom_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .ext_clr(ext_clr), .tx_en(tx_en), .data_valid(data_valid), .data_bit(data_bit),
    .underrun(underrun), .sdlc_mode(sdlc_mode), .abort_on_urun(abort_on_urun),
    .eom_latch(eom_latch), .crc_valid(crc_valid), .crc_bit(crc_bit),
    .abort_req(abort_req), .flag_req(flag_req), .xs_irq(xs_irq),
    .xs_pending(xs_pending)
  );

  // [13:12] code [11] cmd_v [10] ext_clr [9] tx_en [8] urun [7] sdlc [6] abort_opt
  // expected after edge: [5] latch [4] pending [3] irq [2] abort [1] flag [0] crc_valid
  localparam logic [13:0] VEC [15] = '{
    14'b00_0_0_1_0_0_0_100000,  // R1 idle
    14'b00_0_0_1_1_0_0_100000,  // R7 latch set
    14'b11_1_0_1_0_0_0_000000,  // R4 clear
    14'b00_0_0_1_0_0_0_000000,
    14'b00_0_0_1_1_1_1_100100,  // R6 abort
    14'b00_0_0_1_0_1_1_100010,  // R6 flag
    14'b00_0_0_1_0_1_1_100000,
    14'b11_1_0_0_0_0_0_111000,  // R8 disabled, R4 hold
    14'b00_0_0_0_0_0_0_110000,
    14'b11_1_0_0_0_0_0_110000,  // R9 pending blocks
    14'b11_1_1_0_0_0_0_111000,  // R8 with ext_clr
    14'b00_0_1_0_0_0_0_100000,  // R9 ext_clr clears
    14'b11_1_0_1_0_0_0_000000,  // R4
    14'b00_0_0_0_1_0_0_000000,  // R7 disabled
    14'b00_0_0_1_1_1_0_100001   // R5 CRC append
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    logic f = c[15] ^ b;
    return {c[14:0], 1'b0} ^ (f ? 16'h1021 : 16'h0000);
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      cmd_valid = 0; ext_clr = 0; underrun = 0; data_valid = 0;
      @(negedge clk);
    end
  endtask

  task automatic cmd(input logic [1:0] c, input logic en);
    cmd_code = c; cmd_valid = 1; tx_en = en;
    @(negedge clk);
    cmd_valid = 0;
    if (c == 2'b10) m_crc = 16'hFFFF;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      data_valid = 1; data_bit = b[i];
      m_crc = crc_step(m_crc, b[i]);
      @(negedge clk);
    end
    data_valid = 0;
  endtask

  task automatic grab(output logic [15:0] v, output int n);
    v = 0; n = 0;
    tx_en = 1; underrun = 1;
    @(negedge clk);
    underrun = 0;
    for (int i = 0; i < 20; i++) begin
      if (crc_valid) begin
        v = {v[14:0], crc_bit};
        n++;
      end
      if (abort_req) n += 100;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    nbad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int n;
    m_crc = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 reset outputs", {10'd0, eom_latch, xs_pending, xs_irq, abort_req, flag_req, crc_valid},
          16'b100000);
    for (int i = 0; i < 15; i++) begin
      cmd_code = VEC[i][13:12]; cmd_valid = VEC[i][11]; ext_clr = VEC[i][10];
      tx_en = VEC[i][9]; underrun = VEC[i][8]; sdlc_mode = VEC[i][7]; abort_on_urun = VEC[i][6];
      @(negedge clk);
      check($sformatf("R1-9 vector %0d", i),
            {10'd0, eom_latch, xs_pending, xs_irq, abort_req, flag_req, crc_valid},
            {10'd0, VEC[i][5:0]});
    end
    idle(20);
    sdlc_mode = 0; abort_on_urun = 0;

    // R3: CRC of a known stream, 16 bits MSB first
    cmd(2'b10, 1);
    send_byte(8'h31); send_byte(8'h32); send_byte(8'h33);
    cmd(2'b11, 1);
    grab(v, n);
    check("R3 crc length", 16'(n), 16'd16);
    check("R3 crc value", v, m_crc);
    check("R5 latch set after append", {15'd0, eom_latch}, 16'd1);

    // R2: preset command yields all ones
    send_byte(8'h5A);
    cmd(2'b10, 1);
    cmd(2'b11, 1);
    grab(v, n);
    check("R2 preset value", v, 16'hFFFF);

    // R2: block reset keeps CRC state
    cmd(2'b10, 1);
    send_byte(8'hA5);
    rst_n = 0;
    idle(3);
    rst_n = 1;
    check("R1 latch after reset", {15'd0, eom_latch}, 16'd1);
    send_byte(8'h3C);
    cmd(2'b11, 1);
    grab(v, n);
    check("R2 crc across reset", v, m_crc);

    // R5: abort option without SDLC mode still appends CRC
    sdlc_mode = 0; abort_on_urun = 1;
    cmd(2'b10, 1);
    send_byte(8'hC3);
    cmd(2'b11, 1);
    grab(v, n);
    check("R5 non-SDLC appends", 16'(n), 16'd16);
    check("R5 non-SDLC crc", v, m_crc);

    // R7: second underrun with latch set does nothing
    grab(v, n);
    check("R7 no second append", 16'(n), 16'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule